// File: doc/BRIEF.md
# DSD Gate-Drive Retimer

This block takes a one-bit DSD64 audio stream (about 2.8224 MHz) from an upstream converter that is not synchronised to the local clock. It re-times every bit onto a master clock running at exactly eight times the bit rate. Each retimed bit becomes a pulse on one of two complementary gate-drive outputs for a switching power stage. A 1 drives the high-side gate and a 0 drives the low-side gate. Every output edge comes from the master clock. The incoming data only chooses which gate gets the next pulse.

The upstream launches a new data bit on each falling edge of its bit clock. Both inputs pass through synchronisers. The bit is captured half a bit period after the detected falling edge and written into an eight-entry elastic buffer. The read side drains one bit per eight master clocks. The stream has no back-pressure: the source can never be stalled. The buffer handles drift instead. A buffer overflow or underflow drops the lock flag, and both gates stay off until sixteen clean bits have been read out again.

A programmable dead time, counted in master-clock cycles, delays the turn-on of whichever gate is switching on. Three active-low protection flags combine into one active-low error. That error turns both gates off without waiting for a clock edge, and it stays latched until a clear pulse or reset.

Top module: `dsd_gate_retimer`

## Requirements
- R1: Each falling edge of the bit clock writes exactly one bit into the buffer. The bit is the data level sampled four master clocks after the synchronised edge. A bit period that is one master clock short or long must not duplicate or drop a bit.
- R2: A retimed bit of 1 drives only `gate_hi`, and a bit of 0 drives only `gate_lo`. The two outputs are never high in the same cycle.
- R3: When a gate turns on, it is held off for the first `dead_cyc` cycles of its eight-cycle bit period, so it is active for 8 - `dead_cyc` cycles. A setting of 0 behaves as 1.
- R4: When a bit equals the bit before it, the same gate stays on for the whole period with no gap at the boundary.
- R5: The elastic buffer holds 8 bits and starts half full. A write into a full buffer or a read from an empty one clears `locked`, re-centres the buffer and forces both gates off.
- R6: After reset or loss of lock, both gates stay off and `locked` stays 0 until 16 consecutive bits have been read without a buffer error.
- R7: `fault_n` is low whenever any of `flt_ov_n`, `flt_oc_n` or `flt_dc_n` is low. In that case both gates are low in the same cycle, with no clock edge needed.
- R8: A fault is latched. `fault_n` and the gates stay off after the flags return high, until a cycle with `err_clr` high and all flags high, or until reset.
- R9: During and just after reset, `gate_hi` and `gate_lo` are 0, `locked` is 0, and `fault_n` is 1 while all flags are high.
- R10: The idle pattern 1010... gives one pulse per bit with none lost: over any 64 cycles each gate is active 4 × (8 - dead) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, 8 × DSD64 bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| dsd_bclk | input | 1 | Asynchronous DSD bit clock; data launched on its falling edge |
| dsd_bit | input | 1 | Asynchronous DSD data |
| dead_cyc | input | 3 | Dead time in master-clock cycles (0 treated as 1) |
| flt_ov_n | input | 1 | Overvoltage flag, active low |
| flt_oc_n | input | 1 | Overcurrent flag, active low |
| flt_dc_n | input | 1 | DC-offset flag, active low |
| err_clr | input | 1 | Clears the latched fault when all flags are high |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| fault_n | output | 1 | Combined latched error, active low |
| locked | output | 1 | Buffer in lock, gates enabled |

## Verification
Gate-on counts over 64-cycle windows are measured for idle, constant and clustered bit patterns at several dead times. A design that inserted dead time between repeated bits, ignored the zero-as-one rule or lost alternate pulses would give different counts. A run with bit periods of alternately seven and nine cycles checks the sampling point: a duplicated or dropped bit shows up as a hold period or a count change in the same window. Bit clocks that are too fast or stopped must drop lock and silence both gates, and restarting must re-lock. Each fault flag is asserted while a gate is high, and the gates must fall before the next edge and stay off after the flag is released until a clear is issued.

// File: rtl/dsd_rt_pkg.sv
package dsd_rt_pkg;
  typedef struct packed {
    logic ov_n;
    logic oc_n;
    logic dc_n;
  } flt_t;

  // Dead time actually applied: a zero setting still leaves one idle cycle.
  function automatic int dead_eff(input int setting);
    return (setting == 0) ? 1 : setting;
  endfunction
endpackage

// File: rtl/dsd_in_sync.sv
module dsd_in_sync #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_a,
  input  logic data_a,
  output logic wr,
  output logic wr_bit
);
  localparam int CW   = $clog2(OSR) + 1;
  localparam int SAMP = OSR / 2;

  logic [2:0]    bsh;
  logic [1:0]    dsh;
  logic [CW-1:0] cnt;
  logic          fall;

  assign fall = bsh[2] & ~bsh[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsh    <= '0;
      dsh    <= '0;
      cnt    <= '0;
      wr     <= 1'b0;
      wr_bit <= 1'b0;
    end else begin
      bsh <= {bsh[1:0], bclk_a};
      dsh <= {dsh[0], data_a};
      wr  <= 1'b0;
      if (fall) begin
        cnt <= CW'(1);
      end else if (cnt == CW'(SAMP)) begin
        cnt    <= '0;
        wr     <= 1'b1;
        wr_bit <= dsh[1];
      end else if (cnt != '0) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R1
  one_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) wr |=> !wr);
endmodule

// File: rtl/dsd_elastic.sv
module dsd_elastic #(
  parameter int DEPTH    = 8,
  parameter int LOCK_RUN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_bit,
  input  logic rd,
  output logic rd_bit,
  output logic locked
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(LOCK_RUN + 1);
  localparam logic [PW:0] HALF = (PW + 1)'(DEPTH / 2);
  localparam logic [PW:0] FULL = (PW + 1)'(DEPTH);

  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wp, rp;
  logic [PW:0]      cnt;
  logic [LW-1:0]    good;
  logic             ovf, udf, err;

  assign ovf    = wr && !rd && (cnt == FULL);
  assign udf    = rd && (cnt == '0);
  assign err    = ovf || udf;
  assign rd_bit = mem[rp];
  assign locked = (good == LW'(LOCK_RUN));

  always_ff @(posedge clk) begin
    if (!rst_n || err) begin
      wp   <= PW'(DEPTH / 2);
      rp   <= '0;
      cnt  <= HALF;
      good <= '0;
      if (!rst_n) mem <= '0;
    end else begin
      if (wr) begin
        mem[wp] <= wr_bit;
        wp      <= wp + PW'(1);
      end
      if (rd) begin
        rp <= rp + PW'(1);
        if (!locked) good <= good + LW'(1);
      end
      if (wr && !rd)      cnt <= cnt + (PW + 1)'(1);
      else if (rd && !wr) cnt <= cnt - (PW + 1)'(1);
    end
  end

  // R5
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> !locked);
  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
endmodule

// File: rtl/dsd_gate_drive.sv
module dsd_gate_drive
  import dsd_rt_pkg::*;
#(
  parameter int OSR  = 8,
  parameter int DT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [$clog2(OSR)-1:0]  ph,
  input  logic                    new_bit,
  input  logic                    en,
  input  logic [DT_W-1:0]         dead_cyc,
  output logic                    hi_q,
  output logic                    lo_q
);
  logic cur_bit, hold, on_ph;

  always_comb begin
    on_ph = hold || (int'(ph) >= dead_eff(int'(dead_cyc)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bit <= 1'b0;
      hold    <= 1'b0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      hi_q <= en &&  cur_bit && on_ph;
      lo_q <= en && !cur_bit && on_ph;
      if (tick) begin
        cur_bit <= new_bit;
        hold    <= en && (new_bit == cur_bit);
      end
    end
  end

  // R2
  gates_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hi_q && lo_q));
  // R6
  off_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!hi_q && !lo_q));
endmodule

// File: rtl/dsd_fault_gate.sv
module dsd_fault_gate
  import dsd_rt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  flt_t flt,
  input  logic clr,
  output logic fault_n
);
  logic all_ok, latch;

  assign all_ok  = flt.ov_n & flt.oc_n & flt.dc_n;
  assign fault_n = all_ok & ~latch;

  always_ff @(posedge clk) begin
    if (!rst_n)       latch <= 1'b0;
    else if (!all_ok) latch <= 1'b1;
    else if (clr)     latch <= 1'b0;
  end

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr) |=> !fault_n);
endmodule

// File: rtl/dsd_gate_retimer.sv
module dsd_gate_retimer
  import dsd_rt_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int DEPTH    = 8,
  parameter int LOCK_RUN = 16,
  parameter int DT_W     = $clog2(OSR)
) (
  input  logic            mclk,
  input  logic            rst_n,
  input  logic            dsd_bclk,
  input  logic            dsd_bit,
  input  logic [DT_W-1:0] dead_cyc,
  input  logic            flt_ov_n,
  input  logic            flt_oc_n,
  input  logic            flt_dc_n,
  input  logic            err_clr,
  output logic            gate_hi,
  output logic            gate_lo,
  output logic            fault_n,
  output logic            locked
);
  localparam int PHW = $clog2(OSR);

  logic [PHW-1:0] ph;
  logic           tick, wr, wr_bit, rd_bit, hi_q, lo_q;
  flt_t           flt;

  assign tick = (ph == PHW'(OSR - 1));
  assign flt  = '{ov_n: flt_ov_n, oc_n: flt_oc_n, dc_n: flt_dc_n};

  always_ff @(posedge mclk) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph + PHW'(1);
  end

  dsd_in_sync #(.OSR(OSR)) u_sync (
    .clk(mclk), .rst_n(rst_n), .bclk_a(dsd_bclk), .data_a(dsd_bit),
    .wr(wr), .wr_bit(wr_bit)
  );

  dsd_elastic #(.DEPTH(DEPTH), .LOCK_RUN(LOCK_RUN)) u_buf (
    .clk(mclk), .rst_n(rst_n), .wr(wr), .wr_bit(wr_bit), .rd(tick),
    .rd_bit(rd_bit), .locked(locked)
  );

  dsd_gate_drive #(.OSR(OSR), .DT_W(DT_W)) u_drv (
    .clk(mclk), .rst_n(rst_n), .tick(tick), .ph(ph), .new_bit(rd_bit),
    .en(locked), .dead_cyc(dead_cyc), .hi_q(hi_q), .lo_q(lo_q)
  );

  dsd_fault_gate u_flt (
    .clk(mclk), .rst_n(rst_n), .flt(flt), .clr(err_clr), .fault_n(fault_n)
  );

  assign gate_hi = hi_q & fault_n;
  assign gate_lo = lo_q & fault_n;

  // R7
  fault_off_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !(flt_ov_n && flt_oc_n && flt_dc_n) |-> (!gate_hi && !gate_lo && !fault_n));
endmodule

// File: tb/sim_dsd_gate_retimer.sv
module sim_dsd_gate_retimer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dsd_bclk = 1'b0, dsd_bit = 1'b0;
  logic [2:0] dead_cyc = 3'd3;
  logic [2:0] flt_n = 3'b111;
  logic       err_clr = 1'b0;
  logic       gate_hi, gate_lo, fault_n, locked;

  int n_vec = 0, n_bad = 0;
  logic [3:0] pat = 4'b1010;
  int  bper = 8;
  bit  run = 1'b1, jit = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  dsd_gate_retimer u0 (
    .mclk(clk), .rst_n(rst_n), .dsd_bclk(dsd_bclk), .dsd_bit(dsd_bit),
    .dead_cyc(dead_cyc), .flt_ov_n(flt_n[2]), .flt_oc_n(flt_n[1]),
    .flt_dc_n(flt_n[0]), .err_clr(err_clr), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .fault_n(fault_n), .locked(locked)
  );

  // pattern[20:17], dead[16:14], hi cycles[13:7], lo cycles[6:0] per 64 cycles
  localparam logic [20:0] VEC [0:8] = '{
    {4'b1010, 3'd0, 7'd28, 7'd28},
    {4'b1010, 3'd1, 7'd28, 7'd28},
    {4'b1010, 3'd3, 7'd20, 7'd20},
    {4'b1010, 3'd7, 7'd4,  7'd4 },
    {4'b1111, 3'd3, 7'd64, 7'd0 },
    {4'b0000, 3'd5, 7'd0,  7'd64},
    {4'b1100, 3'd2, 7'd28, 7'd28},
    {4'b1100, 3'd7, 7'd18, 7'd18},
    {4'b1110, 3'd4, 7'd40, 7'd8 }
  };

  // Stream source: data changes on falling edge of the bit clock.
  int idx = 3, per = 8;
  bit jphase = 1'b0;
  initial begin
    forever begin
      if (!run) begin
        dsd_bclk = 1'b0;
        @(negedge clk);
      end else begin
        per = bper;
        if (jit) begin
          per = jphase ? 9 : 7;
          jphase = ~jphase;
        end
        dsd_bclk = 1'b1;
        repeat (per / 2) @(negedge clk);
        dsd_bclk = 1'b0;
        dsd_bit  = pat[idx];
        idx      = (idx == 0) ? 3 : idx - 1;
        repeat (per - per / 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n, output int hi, output int lo, output int both, output int unl);
    hi = 0; lo = 0; both = 0; unl = 0;
    repeat (n) begin
      @(posedge clk); #2;
      if (gate_hi) hi++;
      if (gate_lo) lo++;
      if (gate_hi && gate_lo) both++;
      if (!locked) unl++;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  int h, l, b, u, t;
  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R9 reset state
    chk(!gate_hi && !gate_lo, "R9 gates after reset", {gate_hi, gate_lo}, 0);
    chk(!locked, "R9 locked after reset", locked, 0);
    chk(fault_n, "R9 fault_n after reset", fault_n, 1);
    // R6 no output before 16 good reads
    measure(100, h, l, b, u);
    chk(h + l == 0, "R6 gates before lock", h + l, 0);
    chk(u == 100, "R6 locked low before 16 reads", u, 100);
    cyc(150);
    chk(locked, "R6 locked after 16 reads", locked, 1);

    // Vector table: R2 R3 R4 R10
    for (int v = 0; v < 9; v++) begin
      pat = VEC[v][20:17];
      dead_cyc = VEC[v][16:14];
      cyc(80);
      measure(64, h, l, b, u);
      chk(h == int'(VEC[v][13:7]), $sformatf("R3 R4 R10 hi count vec %0d", v), h, int'(VEC[v][13:7]));
      chk(l == int'(VEC[v][6:0]), $sformatf("R3 R4 R10 lo count vec %0d", v), l, int'(VEC[v][6:0]));
      chk(b == 0 && u == 0, $sformatf("R2 exclusive vec %0d", v), b + u, 0);
    end

    // R1 bit periods of 7 and 9 cycles: no duplicated or lost bit
    pat = 4'b1010; dead_cyc = 3'd3;
    cyc(80);
    jit = 1'b1;
    cyc(40);
    measure(128, h, l, b, u);
    chk(u == 0, "R1 lock kept under jitter", u, 0);
    chk(h == 40 && l == 40, "R1 no duplicate bit under jitter", h * 100 + l, 4040);
    jit = 1'b0;

    // R5 overflow: bit clock too fast
    bper = 6;
    t = 0;
    while (locked && t < 300) begin cyc(1); t++; end
    chk(!locked, "R5 lock lost on overflow", locked, 0);
    measure(64, h, l, b, u);
    chk(h + l == 0, "R5 gates off after overflow", h + l, 0);
    bper = 8;
    cyc(300);
    chk(locked, "R6 relock after overflow", locked, 1);

    // R5 underflow: bit clock stopped
    run = 1'b0;
    cyc(100);
    measure(64, h, l, b, u);
    chk(u == 64, "R5 lock lost on underflow", u, 64);
    chk(h + l == 0, "R5 gates off after underflow", h + l, 0);
    run = 1'b1;
    cyc(300);
    chk(locked, "R6 relock after underflow", locked, 1);

    // R7 R8 each fault flag
    for (int f = 0; f < 3; f++) begin
      cyc(40);
      t = 0;
      while (!gate_hi && t < 40) begin cyc(1); t++; end
      chk(gate_hi, "R7 gate high before fault", gate_hi, 1);
      flt_n = ~(3'b001 << f);
      #1;
      chk(!gate_hi && !gate_lo, $sformatf("R7 gates off at once flag %0d", f), {gate_hi, gate_lo}, 0);
      chk(!fault_n, $sformatf("R7 fault_n low flag %0d", f), fault_n, 0);
      cyc(3);
      flt_n = 3'b111;
      cyc(3);
      measure(32, h, l, b, u);
      chk(h + l == 0 && !fault_n, $sformatf("R8 fault latched flag %0d", f), h + l + fault_n, 0);
      err_clr = 1'b1;
      cyc(1);
      err_clr = 1'b0;
      chk(fault_n, $sformatf("R8 cleared flag %0d", f), fault_n, 1);
      measure(64, h, l, b, u);
      chk(h == 20 && l == 20, $sformatf("R8 gates resume flag %0d", f), h * 100 + l, 2020);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule